// File: doc/BRIEF.md
# Partial-Word Store Byte-Lane Unit

This unit converts a partial-word "store bytes" request into one byte-enabled write on a big-endian data memory port that is 8 bytes wide. A request carries a byte address, a store value, a mode bit and a width bit. The mode bit selects one of two behaviours. Begin mode fills the word from the addressed byte to its last byte. End mode fills the word from its first byte up to, but not including, the addressed byte. The width bit selects a 4-byte word or an 8-byte word. The unit computes the aligned bus address, the lane enables and the lane-placed data, and presents them for one write beat.

Each request produces exactly one masked write. A store of 3, 5, 6 or 7 bytes is therefore never split into smaller writes, and no observer can see it half done. An end-mode store at a word-aligned address writes no byte. It still issues a beat with a probe flag set, so that the memory side can check write permission and mark the line dirty. The result is held in a single output register with a valid/ready handshake. A new request is taken only while that register is empty.

Top module: `pwstore_lane_unit`

## Requirements
- R1: After reset the unit holds no pending write: `wr_valid` is 0 and `req_ready` is 1.
- R2: In begin mode with the 8-byte width and offset o = `req_addr[2:0]` not 0, lanes o through 7 are enabled and the rest are not. `wr_data` equals `req_data`, so lane i carries `req_data[63-8i -: 8]` and lane 7 gets the least-significant byte. Lane i is the byte at `wr_addr + i`, and lane 0 is the most-significant byte of the word.
- R3: In begin mode with offset 0, every lane of the selected word is enabled. For the 8-byte width that is all 8 lanes.
- R4: In end mode with the 8-byte width and offset o not 0, lanes 0 through o-1 are enabled. `wr_data` equals `req_data`, so the enabled lanes take the most-significant bytes of the value.
- R5: In end mode with offset 0 (taken at the selected width), no lane is enabled and `wr_probe` is 1. In every other case `wr_probe` is 0.
- R6: With the 4-byte width, the word occupies lanes b..b+3 with b = 4·`req_addr[2]`, and the offset is o = `req_addr[1:0]`. Begin mode enables lanes b+o..b+3. End mode enables lanes b..b+o-1. Both halves of `wr_data` carry `req_data[31:0]`. For example, offset 1 in begin mode gives byte mask 0x00FFFFFF over that word, and offset 3 in end mode gives 0xFFFFFF00.
- R7: Each accepted request produces exactly one write beat. After a beat is taken, `wr_valid` is 0 in the next cycle.
- R8: A request accepted at a clock edge appears on the write outputs from that edge on. `req_ready` is 1 exactly when no beat is pending. While `wr_valid` is 1 and `wr_ready` is 0, all write outputs stay unchanged.
- R9: `wr_addr` is `req_addr` with bits 2:0 cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Store request present |
| req_ready | output | 1 | Request is taken at this edge when valid |
| req_addr | input | ADDR_W | Byte address of the store |
| req_data | input | 8·BUS_LANES | Store value, right-aligned |
| req_end | input | 1 | 0 = begin mode, 1 = end mode |
| req_wide | input | 1 | 0 = 4-byte word, 1 = 8-byte word |
| wr_valid | output | 1 | Write beat pending |
| wr_ready | input | 1 | Memory takes the beat |
| wr_addr | output | ADDR_W | Bus-aligned word address |
| wr_be | output | BUS_LANES | Lane enables, bit i = byte at wr_addr+i |
| wr_data | output | 8·BUS_LANES | Lane-placed write data |
| wr_probe | output | 1 | Empty store; check permission only |

## Verification
The hardest situation to reach is a beat held under backpressure while a second request is already waiting at the input. It matters because only then would a design that overwrites its slot, or accepts into a full slot, be caught. The stimulus holds `wr_ready` low, issues one store, and then presents a second store with different mode and width for several cycles before it releases the ready. The stimulus also sweeps every offset in both modes and both widths, including the aligned end-mode case that writes nothing. A long phase with random ready and random requests then follows.

// File: rtl/pwstore_pkg.sv
package pwstore_pkg;

  typedef enum logic {
    MODE_BEGIN = 1'b0,
    MODE_END   = 1'b1
  } store_mode_e;

  typedef enum logic {
    SIZE_NARROW = 1'b0,
    SIZE_WIDE   = 1'b1
  } store_size_e;

endpackage

// File: rtl/pwstore_lane_mask.sv
module pwstore_lane_mask
  import pwstore_pkg::*;
#(
  parameter int BUS_LANES    = 8,
  parameter int NARROW_LANES = 4,
  localparam int OFS_W       = $clog2(BUS_LANES)
) (
  input  logic [OFS_W-1:0]     byte_ofs,
  input  store_mode_e          mode,
  input  store_size_e          size,
  output logic [BUS_LANES-1:0] lane_en,
  output logic                 probe_only
);

  localparam logic [OFS_W:0] NARROW_MASK = (OFS_W+1)'(NARROW_LANES - 1);

  logic [OFS_W:0] word_base;
  logic [OFS_W:0] word_len;
  logic [OFS_W:0] in_ofs;

  always_comb begin
    if (size == SIZE_WIDE) begin
      word_base = '0;
      word_len  = (OFS_W+1)'(BUS_LANES);
      in_ofs    = {1'b0, byte_ofs};
    end else begin
      word_base = {1'b0, byte_ofs} & ~NARROW_MASK;
      word_len  = (OFS_W+1)'(NARROW_LANES);
      in_ofs    = {1'b0, byte_ofs} & NARROW_MASK;
    end
  end

  for (genvar i = 0; i < BUS_LANES; i++) begin : g_lane
    localparam logic [OFS_W:0] IDX = (OFS_W+1)'(i);
    logic           in_word;
    logic [OFS_W:0] rel;
    always_comb begin
      in_word = (IDX >= word_base) && (IDX < word_base + word_len);
      rel     = IDX - word_base;
      if (mode == MODE_END) begin
        lane_en[i] = in_word && (rel < in_ofs);
      end else begin
        lane_en[i] = in_word && (rel >= in_ofs);
      end
    end
  end

  assign probe_only = (mode == MODE_END) && (in_ofs == '0);

endmodule

// File: rtl/pwstore_data_steer.sv
module pwstore_data_steer
  import pwstore_pkg::*;
#(
  parameter int BUS_LANES    = 8,
  parameter int NARROW_LANES = 4,
  localparam int BUS_W       = 8 * BUS_LANES,
  localparam int NARROW_W    = 8 * NARROW_LANES,
  localparam int COPIES      = BUS_LANES / NARROW_LANES
) (
  input  logic [BUS_W-1:0] value,
  input  store_size_e      size,
  output logic [BUS_W-1:0] lane_data
);

  logic [BUS_W-1:0] narrow_rep;

  for (genvar k = 0; k < COPIES; k++) begin : g_copy
    assign narrow_rep[k*NARROW_W +: NARROW_W] = value[NARROW_W-1:0];
  end

  assign lane_data = (size == SIZE_WIDE) ? value : narrow_rep;

endmodule

// File: rtl/pwstore_out_slot.sv
module pwstore_out_slot #(
  parameter int ADDR_W    = 32,
  parameter int BUS_LANES = 8,
  localparam int BUS_W    = 8 * BUS_LANES
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [ADDR_W-1:0]    in_addr,
  input  logic [BUS_LANES-1:0] in_be,
  input  logic [BUS_W-1:0]     in_data,
  input  logic                 in_probe,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [ADDR_W-1:0]    out_addr,
  output logic [BUS_LANES-1:0] out_be,
  output logic [BUS_W-1:0]     out_data,
  output logic                 out_probe
);

  logic full_q, full_d;
  logic load;

  always_comb begin
    in_ready = rst_n && !full_q;
    load     = in_valid && in_ready;
    full_d   = full_q;
    if (full_q && out_ready) full_d = 1'b0;
    if (load)                full_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) full_q <= 1'b0;
    else        full_q <= full_d;
  end

  always_ff @(posedge clk) begin
    if (load) begin
      out_addr  <= in_addr;
      out_be    <= in_be;
      out_data  <= in_data;
      out_probe <= in_probe;
    end
  end

  assign out_valid = full_q;

  // R8: a stalled beat keeps all of its fields
  a_r8_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_addr) && $stable(out_be)
                                && $stable(out_data) && $stable(out_probe));

endmodule

// File: rtl/pwstore_lane_unit.sv
module pwstore_lane_unit
  import pwstore_pkg::*;
#(
  parameter int ADDR_W       = 32,
  parameter int BUS_LANES    = 8,
  parameter int NARROW_LANES = 4,
  localparam int BUS_W       = 8 * BUS_LANES,
  localparam int OFS_W       = $clog2(BUS_LANES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [BUS_W-1:0]     req_data,
  input  logic                 req_end,
  input  logic                 req_wide,
  output logic                 wr_valid,
  input  logic                 wr_ready,
  output logic [ADDR_W-1:0]    wr_addr,
  output logic [BUS_LANES-1:0] wr_be,
  output logic [BUS_W-1:0]     wr_data,
  output logic                 wr_probe
);

  // reset: asserted at once, released through two flops
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  store_mode_e          mode;
  store_size_e          size;
  logic [BUS_LANES-1:0] lane_en;
  logic                 probe_only;
  logic [BUS_W-1:0]     lane_data;
  logic [ADDR_W-1:0]    aligned_addr;

  assign mode         = store_mode_e'(req_end);
  assign size         = store_size_e'(req_wide);
  assign aligned_addr = {req_addr[ADDR_W-1:OFS_W], {OFS_W{1'b0}}};

  pwstore_lane_mask #(
    .BUS_LANES    (BUS_LANES),
    .NARROW_LANES (NARROW_LANES)
  ) i_mask (
    .byte_ofs   (req_addr[OFS_W-1:0]),
    .mode       (mode),
    .size       (size),
    .lane_en    (lane_en),
    .probe_only (probe_only)
  );

  pwstore_data_steer #(
    .BUS_LANES    (BUS_LANES),
    .NARROW_LANES (NARROW_LANES)
  ) i_steer (
    .value     (req_data),
    .size      (size),
    .lane_data (lane_data)
  );

  pwstore_out_slot #(
    .ADDR_W    (ADDR_W),
    .BUS_LANES (BUS_LANES)
  ) i_slot (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .in_valid  (req_valid),
    .in_ready  (req_ready),
    .in_addr   (aligned_addr),
    .in_be     (lane_en),
    .in_data   (lane_data),
    .in_probe  (probe_only),
    .out_valid (wr_valid),
    .out_ready (wr_ready),
    .out_addr  (wr_addr),
    .out_be    (wr_be),
    .out_data  (wr_data),
    .out_probe (wr_probe)
  );

  a_r5_probe_no_lanes: assert property (@(posedge clk) disable iff (!rst_n || !rst_sync_q)
    wr_valid && wr_probe |-> wr_be == '0);

  a_r2_begin_writes: assert property (@(posedge clk) disable iff (!rst_n || !rst_sync_q)
    req_valid && req_ready && !req_end |=> wr_be != '0 && !wr_probe);

  a_r6_narrow_span: assert property (@(posedge clk) disable iff (!rst_n || !rst_sync_q)
    req_valid && req_ready && !req_wide |=> $countones(wr_be) <= NARROW_LANES);

  a_r7_single_beat: assert property (@(posedge clk) disable iff (!rst_n || !rst_sync_q)
    wr_valid && wr_ready |=> !wr_valid);

  a_r8_accept_shows: assert property (@(posedge clk) disable iff (!rst_n || !rst_sync_q)
    req_valid && req_ready |=> wr_valid);

  a_r9_aligned: assert property (@(posedge clk) disable iff (!rst_n || !rst_sync_q)
    wr_valid |-> wr_addr[OFS_W-1:0] == '0);

endmodule

// File: tb/test_pwstore_lane_unit.sv
module test_pwstore_lane_unit;

  localparam int AW = 32;
  localparam int NL = 8;
  localparam int DW = 64;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid;
  logic          req_ready;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_data;
  logic          req_end;
  logic          req_wide;
  logic          wr_valid;
  logic          wr_ready;
  logic [AW-1:0] wr_addr;
  logic [NL-1:0] wr_be;
  logic [DW-1:0] wr_data;
  logic          wr_probe;

  always #5 clk = ~clk;

  pwstore_lane_unit i_pwstore_lane_unit (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_data(req_data), .req_end(req_end), .req_wide(req_wide),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
    .wr_be(wr_be), .wr_data(wr_data), .wr_probe(wr_probe)
  );

  int vectors = 0;
  int fails   = 0;
  int cycles  = 0;
  int rdy_mode = 0;
  bit cmp_en  = 0;

  logic [AW-1:0] q_addr[$];
  logic [NL-1:0] q_be[$];
  logic [DW-1:0] q_data[$];
  logic          q_probe[$];
  string         q_tag[$];

  task automatic report(string tag, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // behavioural reference: lane i is the byte at the aligned address plus i
  function automatic logic [NL-1:0] ref_be(logic [AW-1:0] a, logic e, logic w);
    int wl    = w ? 8 : 4;
    int base  = w ? 0 : (a[2] ? 4 : 0);
    int o     = w ? int'(a[2:0]) : int'(a[1:0]);
    int start = e ? base : base + o;
    int n     = e ? o : wl - o;
    logic [NL-1:0] m = '0;
    for (int k = 0; k < n; k++) m[start+k] = 1'b1;
    return m;
  endfunction

  function automatic string ref_tag(logic [AW-1:0] a, logic e, logic w);
    int o = w ? int'(a[2:0]) : int'(a[1:0]);
    if (e && o == 0)  return "R5";
    if (!e && o == 0) return "R3";
    if (!w)           return "R6";
    if (!e)           return "R2";
    return "R4";
  endfunction

  // compare and model update, away from the active edge
  always @(negedge clk) begin
    if (cmp_en) begin
      logic exp_ready;
      exp_ready = (q_be.size() == 0);
      report("R8", "req_ready", DW'(req_ready), DW'(exp_ready));
      report("R7", "wr_valid", DW'(wr_valid), DW'(!exp_ready));
      if (!exp_ready && wr_valid) begin
        report("R9", "wr_addr", DW'(wr_addr), DW'(q_addr[0]));
        report(q_tag[0], "wr_be", DW'(wr_be), DW'(q_be[0]));
        report(q_tag[0], "wr_data", wr_data, q_data[0]);
        report("R5", "wr_probe", DW'(wr_probe), DW'(q_probe[0]));
      end
      if (!exp_ready && wr_ready) begin
        void'(q_addr.pop_front()); void'(q_be.pop_front());
        void'(q_data.pop_front()); void'(q_probe.pop_front());
        void'(q_tag.pop_front());
      end
      if (exp_ready && req_valid) begin
        int o;
        o = req_wide ? int'(req_addr[2:0]) : int'(req_addr[1:0]);
        q_addr.push_back({req_addr[AW-1:3], 3'b000});
        q_be.push_back(ref_be(req_addr, req_end, req_wide));
        q_data.push_back(req_wide ? req_data : {req_data[31:0], req_data[31:0]});
        q_probe.push_back(req_end && o == 0);
        q_tag.push_back(ref_tag(req_addr, req_end, req_wide));
      end
    end
  end

  initial begin
    forever begin
      @(posedge clk); #1;
      case (rdy_mode)
        0:       wr_ready = 1'b1;
        1:       wr_ready = 1'($urandom % 2);
        default: wr_ready = 1'b0;
      endcase
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  task automatic drive(logic [AW-1:0] a, logic [DW-1:0] d, logic e, logic w);
    req_valid = 1'b1; req_addr = a; req_data = d; req_end = e; req_wide = w;
  endtask

  task automatic wait_accept();
    forever begin
      @(negedge clk);
      if (req_ready) break;
    end
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic send(logic [AW-1:0] a, logic [DW-1:0] d, logic e, logic w);
    drive(a, d, e, w);
    wait_accept();
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_data = '0;
    req_end = 1'b0; req_wide = 1'b0; wr_ready = 1'b1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    report("R1", "req_ready after reset", DW'(req_ready), DW'(1));
    report("R1", "wr_valid after reset", DW'(wr_valid), DW'(0));
    cmp_en = 1'b1;
    @(posedge clk); #1;

    // sweep every offset, both modes, both widths (R2 R3 R4 R5 R6)
    for (int w = 0; w < 2; w++)
      for (int e = 0; e < 2; e++)
        for (int o = 0; o < 8; o++)
          send({$urandom, 3'(o)} & 32'hFFFF_FFFF, {$urandom, $urandom}, 1'(e), 1'(w));

    // stalled beat with a second request waiting (R8)
    rdy_mode = 2;
    @(posedge clk); #1;
    send(32'h0000_1235, 64'h0102_0304_0506_0708, 1'b0, 1'b1);
    drive(32'h0000_2346, 64'h1122_3344_5566_7788, 1'b1, 1'b0);
    repeat (6) @(posedge clk);
    #1 rdy_mode = 0;
    wait_accept();

    // random traffic with random backpressure (R7 R8 R9)
    rdy_mode = 1;
    for (int n = 0; n < 300; n++) begin
      send($urandom, {$urandom, $urandom}, 1'($urandom), 1'($urandom));
      repeat ($urandom % 3) @(posedge clk);
      #0;
    end

    rdy_mode = 0;
    repeat (6) @(posedge clk);
    @(negedge clk);
    cmp_en = 1'b0;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule